// File: doc/BRIEF.md
# Packet-Filter Arithmetic Execution Unit

This unit executes the arithmetic instructions of a 64-bit packet-filter virtual machine. Each instruction arrives with an 8-bit opcode, the value of the destination register, the value of the source register and a 32-bit immediate. The unit returns the value to write back, a write-enable flag and an illegal-instruction flag. The surrounding pipeline owns the register file, fetch, memory and branches.

The opcode has three fields. The class field picks 32-bit or 64-bit operation. Bit 3 chooses between the immediate and the source register. The top nibble names the operation. The 32-bit class works on the low halves of its operands and returns a zero-extended result. Byte swap reads only the destination register and takes its width from the immediate. The host is treated as little-endian.

Most operations finish one cycle after acceptance and can be issued back to back. Unsigned divide and modulo go through a restoring divider that produces one quotient bit per cycle. While the divider works, `in_ready_o` stays low, and a one-cycle `out_valid_o` pulse marks the result.

Top module: `pf_alu`

## Requirements
- R1: Only class values 3'h4 (32-bit) and 3'h7 (64-bit) in opcode[2:0] are executed. Any other class sets `illegal_o`, clears `wr_en_o` and returns 0.
- R2: opcode[3]=1 selects the source register as the second operand. opcode[3]=0 selects the immediate, sign-extended to 64 bits. In the 64-bit class, opcode[7:4] codes 0..0xc are: add, sub, mul, div, or, and, shl, lshr, neg, mod, xor, mov, ashr.
- R3: In the 32-bit class, every operation except byte swap uses only bits [31:0] of both operands, and the result's upper 32 bits are zero.
- R4: The shift amount is the second operand masked to 5 bits in the 32-bit class and to 6 bits in the 64-bit class.
- R5: Negate (0x8) returns the two's complement of the destination and ignores the second operand. Move (0xb) returns the second operand. Arithmetic right shift (0xc) replicates the sign bit of the 32-bit or 64-bit operand.
- R6: Byte swap (0xd) with opcode[3]=0 returns the low 16 or 32 bits of the destination zero-extended, or all 64 bits unchanged. It ignores the source register.
- R7: Byte swap with opcode[3]=1 reverses the byte order within the low 16, 32 or 64 bits of the destination and zero-extends the result.
- R8: A byte swap whose immediate is not 16, 32 or 64 is illegal: `illegal_o`=1, `wr_en_o`=0, result 0.
- R9: Operation codes 0xe and 0xf are illegal: `illegal_o`=1, `wr_en_o`=0, result 0.
- R10: Divide (0x3) and modulo (0x9) are unsigned. `in_ready_o` drops the cycle after acceptance and rises again with the single-cycle `out_valid_o` pulse. `out_valid_o` is never high while `in_ready_o` is low.
- R11: Divide by zero returns 0. Modulo by zero returns the dividend, which in the 32-bit class is the zero-extended low half of the destination.
- R12: Every other instruction raises `out_valid_o` for exactly the cycle after acceptance. A new instruction can be accepted every cycle.
- R13: After reset, `in_ready_o`=1 and `out_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction present |
| in_ready_o | output | 1 | Unit can accept an instruction |
| opcode_i | input | 8 | Operation, operand select and class |
| dst_i | input | 64 | Destination register value |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate field |
| out_valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 64 | Value to write back |
| wr_en_o | output | 1 | Write the destination register |
| illegal_o | output | 1 | Instruction not executable |

## Verification
The assertions assume that `in_valid_i` is only considered while `in_ready_o` is high. They also assume that the opcode of an accepted instruction stays paired with the next result strobe. Both hold because the unit has no queue, and the checker records the opcode at acceptance. The stimulus presents one instruction at a time and waits for ready before the next, except in one directed back-to-back pair of single-cycle operations. Random opcodes mostly stay within the legal classes. Deliberate illegal classes, operation codes and swap widths are mixed in. Divisors are forced to zero often enough to reach the divide-by-zero paths.

// File: rtl/pf_alu_pkg.sv
package pf_alu_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned HLEN = XLEN / 2;

  localparam logic [2:0] CLS_W32 = 3'h4;
  localparam logic [2:0] CLS_W64 = 3'h7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV  = 4'h3,
    OP_OR   = 4'h4, OP_AND  = 4'h5, OP_SHL  = 4'h6, OP_SHR  = 4'h7,
    OP_NEG  = 4'h8, OP_MOD  = 4'h9, OP_XOR  = 4'ha, OP_MOV  = 4'hb,
    OP_ASHR = 4'hc, OP_SWAP = 4'hd
  } alu_op_e;

  typedef enum logic [1:0] {SW_16 = 2'd0, SW_32 = 2'd1, SW_64 = 2'd2} swap_w_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_DIV = 1'b1} ctl_state_e;
endpackage

// File: rtl/pf_alu_decode.sv
module pf_alu_decode
  import pf_alu_pkg::*;
(
  input  logic [7:0]      opcode_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [31:0]     imm_i,
  output logic [3:0]      op_o,
  output logic            is32_o,
  output logic            sel_reg_o,
  output logic [XLEN-1:0] opnd_o,
  output swap_w_e         swap_w_o,
  output logic            is_div_o,
  output logic            illegal_o
);
  logic [2:0] cls;
  logic       cls_ok;
  logic       w_ok;

  assign cls       = opcode_i[2:0];
  assign op_o      = opcode_i[7:4];
  assign sel_reg_o = opcode_i[3];
  assign is32_o    = (cls == CLS_W32);
  assign cls_ok    = (cls == CLS_W32) || (cls == CLS_W64);
  assign opnd_o    = sel_reg_o ? src_i : {{(XLEN-32){imm_i[31]}}, imm_i};

  always_comb begin
    w_ok     = 1'b1;
    swap_w_o = SW_64;
    unique case (imm_i)
      32'd16:  swap_w_o = SW_16;
      32'd32:  swap_w_o = SW_32;
      32'd64:  swap_w_o = SW_64;
      default: w_ok = 1'b0;
    endcase
  end

  assign is_div_o  = (op_o == OP_DIV) || (op_o == OP_MOD);
  assign illegal_o = !cls_ok || (op_o > OP_SWAP) || ((op_o == OP_SWAP) && !w_ok);
endmodule

// File: rtl/pf_alu_exec.sv
module pf_alu_exec
  import pf_alu_pkg::*;
(
  input  logic [3:0]      op_i,
  input  logic            is32_i,
  input  logic            big_end_i,
  input  swap_w_e         swap_w_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned NB = XLEN / 8;

  logic [HLEN-1:0] a32, b32, r32;
  logic [XLEN-1:0] r64, swp, rev;
  logic [5:0]      sh64;
  logic [4:0]      sh32;

  assign a32  = a_i[HLEN-1:0];
  assign b32  = b_i[HLEN-1:0];
  assign sh64 = b_i[5:0];
  assign sh32 = b_i[4:0];

  always_comb begin
    unique case (op_i)
      OP_ADD:  r64 = a_i + b_i;
      OP_SUB:  r64 = a_i - b_i;
      OP_MUL:  r64 = a_i * b_i;
      OP_OR:   r64 = a_i | b_i;
      OP_AND:  r64 = a_i & b_i;
      OP_SHL:  r64 = a_i << sh64;
      OP_SHR:  r64 = a_i >> sh64;
      OP_NEG:  r64 = -a_i;
      OP_XOR:  r64 = a_i ^ b_i;
      OP_MOV:  r64 = b_i;
      OP_ASHR: r64 = $unsigned($signed(a_i) >>> sh64);
      default: r64 = '0;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_ADD:  r32 = a32 + b32;
      OP_SUB:  r32 = a32 - b32;
      OP_MUL:  r32 = a32 * b32;
      OP_OR:   r32 = a32 | b32;
      OP_AND:  r32 = a32 & b32;
      OP_SHL:  r32 = a32 << sh32;
      OP_SHR:  r32 = a32 >> sh32;
      OP_NEG:  r32 = -a32;
      OP_XOR:  r32 = a32 ^ b32;
      OP_MOV:  r32 = b32;
      OP_ASHR: r32 = $unsigned($signed(a32) >>> sh32);
      default: r32 = '0;
    endcase
  end

  // byte reversal inside the selected width, upper bytes cleared
  always_comb begin
    rev = '0;
    unique case (swap_w_i)
      SW_16: for (int i = 0; i < 2; i++)  rev[8*i +: 8] = a_i[8*(1-i) +: 8];
      SW_32: for (int i = 0; i < 4; i++)  rev[8*i +: 8] = a_i[8*(3-i) +: 8];
      default: for (int i = 0; i < NB; i++) rev[8*i +: 8] = a_i[8*(NB-1-i) +: 8];
    endcase
  end

  always_comb begin
    if (big_end_i) swp = rev;
    else begin
      unique case (swap_w_i)
        SW_16:   swp = {{(XLEN-16){1'b0}}, a_i[15:0]};
        SW_32:   swp = {{(XLEN-32){1'b0}}, a_i[31:0]};
        default: swp = a_i;
      endcase
    end
  end

  always_comb begin
    if (op_i == OP_SWAP) res_o = swp;
    else if (is32_i)     res_o = {{(XLEN-HLEN){1'b0}}, r32};
    else                 res_o = r64;
  end
endmodule

// File: rtl/pf_alu_div.sv
module pf_alu_div #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    shifted, trial;
  logic          qbit;
  logic [W-1:0]  rem_nxt;
  logic          last;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign qbit    = !trial[W];
  assign rem_nxt = qbit ? trial[W-1:0] : shifted[W-1:0];
  assign last    = busy_q && (cnt_q == CW'(W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nxt;
        quo_q <= {quo_q[W-2:0], qbit};
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign quot_o = quo_q;
  assign rem_o  = rem_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/pf_alu.sv
module pf_alu
  import pf_alu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [7:0]      opcode_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [31:0]     imm_i,
  output logic            out_valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            wr_en_o,
  output logic            illegal_o
);
  logic [3:0]      d_op;
  logic            d_is32, d_sel_reg, d_is_div, d_illegal;
  logic [XLEN-1:0] d_opnd, x_res;
  swap_w_e         d_swap_w;

  logic [XLEN-1:0] dv_a, dv_b, dv_quot, dv_rem;
  logic            dv_start, dv_busy, dv_done;

  ctl_state_e      state_q;
  logic            pend_mod_q, pend_zero_q;
  logic            accept;

  pf_alu_decode u_dec (
    .opcode_i (opcode_i),
    .src_i    (src_i),
    .imm_i    (imm_i),
    .op_o     (d_op),
    .is32_o   (d_is32),
    .sel_reg_o(d_sel_reg),
    .opnd_o   (d_opnd),
    .swap_w_o (d_swap_w),
    .is_div_o (d_is_div),
    .illegal_o(d_illegal)
  );

  pf_alu_exec u_exec (
    .op_i     (d_op),
    .is32_i   (d_is32),
    .big_end_i(d_sel_reg),
    .swap_w_i (d_swap_w),
    .a_i      (dst_i),
    .b_i      (d_opnd),
    .res_o    (x_res)
  );

  assign dv_a     = d_is32 ? {{(XLEN-HLEN){1'b0}}, dst_i[HLEN-1:0]}  : dst_i;
  assign dv_b     = d_is32 ? {{(XLEN-HLEN){1'b0}}, d_opnd[HLEN-1:0]} : d_opnd;
  assign accept   = in_valid_i && in_ready_o;
  assign dv_start = accept && d_is_div && !d_illegal;

  pf_alu_div #(.W(XLEN)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (dv_start),
    .dividend_i(dv_a),
    .divisor_i (dv_b),
    .quot_o    (dv_quot),
    .rem_o     (dv_rem),
    .busy_o    (dv_busy),
    .done_o    (dv_done)
  );

  assign in_ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_mod_q  <= 1'b0;
      pend_zero_q <= 1'b0;
      out_valid_o <= 1'b0;
      result_o    <= '0;
      wr_en_o     <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (dv_start) begin
            state_q     <= ST_DIV;
            pend_mod_q  <= (d_op == OP_MOD);
            pend_zero_q <= (dv_b == '0);
          end else if (accept) begin
            out_valid_o <= 1'b1;
            result_o    <= d_illegal ? '0 : x_res;
            wr_en_o     <= !d_illegal;
            illegal_o   <= d_illegal;
          end
        end
        ST_DIV: begin
          // divider leaves the dividend in the remainder when the divisor is zero
          if (dv_done && !dv_busy) begin
            state_q     <= ST_IDLE;
            out_valid_o <= 1'b1;
            result_o    <= pend_mod_q ? dv_rem : (pend_zero_q ? '0 : dv_quot);
            wr_en_o     <= 1'b1;
            illegal_o   <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pf_alu_chk.sv
module pf_alu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [7:0]  opcode_i,
  input logic        out_valid_o,
  input logic [63:0] result_o,
  input logic        wr_en_o,
  input logic        illegal_o
);
  logic [7:0] cap_q;
  logic       acc, cls_ok_in, div_in, cap_w32, cap_cls_ok;

  assign acc        = in_valid_i && in_ready_o;
  assign cls_ok_in  = (opcode_i[2:0] == 3'h4) || (opcode_i[2:0] == 3'h7);
  assign div_in     = cls_ok_in && ((opcode_i[7:4] == 4'h3) || (opcode_i[7:4] == 4'h9));
  assign cap_w32    = (cap_q[2:0] == 3'h4);
  assign cap_cls_ok = cap_w32 || (cap_q[2:0] == 3'h7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cap_q <= 8'h0;
    else if (acc) cap_q <= opcode_i;
  end

  assert_bad_class_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !cap_cls_ok |-> illegal_o && !wr_en_o);

  assert_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && wr_en_o && cap_w32 && (cap_q[7:4] != 4'hd) |-> result_o[63:32] == 32'h0);

  assert_no_write_illegal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && illegal_o |-> !wr_en_o && (result_o == 64'h0));

  assert_div_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && div_in |=> !in_ready_o);

  assert_quiet_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> !out_valid_o);

  assert_one_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !div_in |=> out_valid_o && in_ready_o);
endmodule

bind pf_alu pf_alu_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .opcode_i   (opcode_i),
  .out_valid_o(out_valid_o),
  .result_o   (result_o),
  .wr_en_o    (wr_en_o),
  .illegal_o  (illegal_o)
);

// File: tb/tb_pf_alu.sv
module tb_pf_alu;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 500;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  opcode_i = 8'h0;
  logic [63:0] dst_i = '0, src_i = '0;
  logic [31:0] imm_i = '0;
  logic        out_valid_o;
  logic [63:0] result_o;
  logic        wr_en_o, illegal_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pf_alu dut (.*);

  function automatic void model(input logic [7:0] opc, input logic [63:0] d, s,
                                input logic [31:0] im, output logic [63:0] r,
                                output logic ill);
    logic [2:0]  c;
    logic [3:0]  o;
    logic [63:0] b;
    logic [31:0] x, y, z;
    int nb;
    c = opc[2:0];
    o = opc[7:4];
    b = opc[3] ? s : {{32{im[31]}}, im};
    ill = (c != 3'h4 && c != 3'h7) || (o > 4'hd) ||
          (o == 4'hd && im != 32'd16 && im != 32'd32 && im != 32'd64);
    r = '0;
    if (ill) return;
    if (o == 4'hd) begin
      nb = int'(im) / 8;
      if (!opc[3]) r = (nb == 8) ? d : (d & ((64'd1 << (8*nb)) - 1));
      else for (int k = 0; k < nb; k++) r[8*k +: 8] = d[8*(nb-1-k) +: 8];
    end else if (c == 3'h4) begin
      x = d[31:0];
      y = b[31:0];
      case (o)
        4'h0: z = x + y;
        4'h1: z = x - y;
        4'h2: z = x * y;
        4'h3: z = (y == 0) ? 32'h0 : x / y;
        4'h4: z = x | y;
        4'h5: z = x & y;
        4'h6: z = x << y[4:0];
        4'h7: z = x >> y[4:0];
        4'h8: z = 32'h0 - x;
        4'h9: z = (y == 0) ? x : x % y;
        4'ha: z = x ^ y;
        4'hb: z = y;
        default: z = $unsigned($signed(x) >>> y[4:0]);
      endcase
      r = {32'h0, z};
    end else begin
      case (o)
        4'h0: r = d + b;
        4'h1: r = d - b;
        4'h2: r = d * b;
        4'h3: r = (b == 0) ? 64'h0 : d / b;
        4'h4: r = d | b;
        4'h5: r = d & b;
        4'h6: r = d << b[5:0];
        4'h7: r = d >> b[5:0];
        4'h8: r = 64'h0 - d;
        4'h9: r = (b == 0) ? d : d % b;
        4'ha: r = d ^ b;
        4'hb: r = b;
        default: r = $unsigned($signed(d) >>> b[5:0]);
      endcase
    end
  endfunction

  function automatic string tag_of(input logic [7:0] opc, input logic [63:0] s,
                                   input logic [31:0] im);
    logic [63:0] b;
    logic [3:0]  o;
    o = opc[7:4];
    b = opc[3] ? s : {{32{im[31]}}, im};
    if (opc[2:0] != 3'h4 && opc[2:0] != 3'h7) return "R1";
    if (o > 4'hd) return "R9";
    if (o == 4'hd) begin
      if (im != 32'd16 && im != 32'd32 && im != 32'd64) return "R8";
      return opc[3] ? "R7" : "R6";
    end
    if (o == 4'h3 || o == 4'h9) begin
      if ((opc[2:0] == 3'h4 && b[31:0] == 0) || b == 0) return "R11";
      return "R10";
    end
    if (o == 4'h6 || o == 4'h7) return "R4";
    if (o == 4'h8 || o == 4'hb || o == 4'hc) return "R5";
    if (opc[2:0] == 3'h4) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [7:0] opc, input logic [63:0] d, s,
                         input logic [31:0] im);
    logic [63:0] er;
    logic        eill;
    int          lat;
    string       tg;
    model(opc, d, s, im, er, eill);
    tg = tag_of(opc, s, im);
    while (!in_ready_o) @(negedge clk_i);
    opcode_i = opc; dst_i = d; src_i = s; imm_i = im; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    lat = 0;
    while (!out_valid_o && lat < 200) begin
      @(negedge clk_i);
      lat++;
    end
    check(tg, "result", result_o, er);
    check(tg, "illegal", {63'h0, illegal_o}, {63'h0, eill});
    check(tg, "wr_en", {63'h0, wr_en_o}, {63'h0, !eill});
    if (tg != "R10" && tg != "R11")
      check("R12", "latency", 64'(lat), 64'd0);
    else
      check("R10", "div completes", 64'(lat < 70), 64'd1);
    @(negedge clk_i);
    check(tg, "strobe one cycle", {63'h0, out_valid_o}, 64'h0);
  endtask

  initial begin
    repeat (20000 * 5) @(posedge clk_i);
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] er;
    logic        eill;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check("R13", "ready in reset", {63'h0, in_ready_o}, 64'h1);
    check("R13", "valid in reset", {63'h0, out_valid_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R13", "ready after reset", {63'h0, in_ready_o}, 64'h1);
    check("R13", "valid after reset", {63'h0, out_valid_o}, 64'h0);

    // directed corners
    run_vec(8'h0c, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_0000_0000_0002, 32'h0); // R3 add wraps low half
    run_vec(8'h07, 64'h10, 64'h0, 32'hFFFF_FFFF);                          // R2 imm sext
    run_vec(8'h6f, 64'h1, 64'h43, 32'h0);                                   // R4 shift mask 64
    run_vec(8'h6c, 64'h1, 64'h23, 32'h0);                                   // R4 shift mask 32
    run_vec(8'hc4, 64'h0, 64'h0, 32'h4);                                    // R5 ashr imm, low half 0
    run_vec(8'hcc, 64'h8000_0000, 64'h4, 32'h0);                            // R5 ashr32 sign
    run_vec(8'h8f, 64'h5, 64'hDEAD, 32'h0);                                 // R5 neg ignores src
    run_vec(8'hd4, 64'h1122_3344_5566_7788, 64'h0, 32'd16);                 // R6
    run_vec(8'hd4, 64'h1122_3344_5566_7788, 64'hF, 32'd64);                 // R6
    run_vec(8'hdc, 64'h1122_3344_5566_7788, 64'h0, 32'd16);                 // R7
    run_vec(8'hdc, 64'h1122_3344_5566_7788, 64'h0, 32'd32);                 // R7
    run_vec(8'hdc, 64'h1122_3344_5566_7788, 64'h0, 32'd64);                 // R7
    run_vec(8'hd4, 64'h1122_3344_5566_7788, 64'h0, 32'd8);                  // R8
    run_vec(8'he7, 64'h1, 64'h2, 32'h3);                                    // R9
    run_vec(8'hff, 64'h1, 64'h2, 32'h3);                                    // R9
    run_vec(8'h05, 64'h1, 64'h2, 32'h3);                                    // R1
    run_vec(8'h3f, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3, 32'h0);                  // R10 unsigned
    run_vec(8'h3f, 64'h77, 64'h0, 32'h0);                                   // R11 div by 0
    run_vec(8'h9c, 64'hABCD_0000_1234_5678, 64'h1_0000_0000, 32'h0);        // R11 mod by 0, 32-bit
    run_vec(8'h97, 64'h8000_0000_0000_0005, 64'h0, 32'h7);                  // R10 mod imm

    // R12 back-to-back single-cycle ops
    while (!in_ready_o) @(negedge clk_i);
    opcode_i = 8'h07; dst_i = 64'd40; imm_i = 32'd2; in_valid_i = 1'b1;
    @(negedge clk_i);
    opcode_i = 8'haf; dst_i = 64'hF0; src_i = 64'h0F;
    check("R12", "first valid", {63'h0, out_valid_o}, 64'h1);
    check("R12", "first result", result_o, 64'd42);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R12", "second valid", {63'h0, out_valid_o}, 64'h1);
    check("R12", "second result", result_o, 64'hFF);
    @(negedge clk_i);

    for (int n = 0; n < N_RAND; n++) begin
      logic [7:0]  opc;
      logic [63:0] d, s;
      logic [31:0] im;
      int          pick;
      pick = $urandom_range(0, 15);
      opc = {4'($urandom_range(0, 13)), 1'($urandom), ($urandom_range(0, 1) != 0) ? 3'h7 : 3'h4};
      if (pick == 0) opc = 8'($urandom);
      d  = {$urandom, $urandom};
      s  = {$urandom, $urandom};
      im = $urandom;
      if (pick == 1) s = '0;
      if (pick == 2) im = '0;
      if (pick == 3) s = 64'($urandom_range(1, 300));
      if (opc[7:4] == 4'hd) begin
        case ($urandom_range(0, 3))
          0: im = 32'd16;
          1: im = 32'd32;
          2: im = 32'd64;
          default: im = 32'($urandom_range(0, 100));
        endcase
      end
      run_vec(opc, d, s, im);
    end

    model(8'h00, 64'h0, 64'h0, 32'h0, er, eill);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule